// File: doc/BRIEF.md
# Per-Step Output Capture Buffer

This block gathers the results that fabric logic produces on a set of output ports during one calculation step, and presents them to a host-transfer engine once that step closes. Each port takes a 33-bit word. The most significant bit is a write strobe and the lower 32 bits are the payload. A mode mask chooses how each port captures.

- In register mode, a port keeps only the most recent strobed word.
- In FIFO mode, a port keeps every strobed word, in arrival order, up to a fixed depth of 254.

The step boundary of a port is normally the global step pulse. A port can instead be told to follow its own external pulse, which may arrive up to 15 cycles after the global pulse. Each port holds two banks. At its boundary the filled bank changes over to drain duty, and writes continue into the other bank. The transfer engine selects a port and reads its drained words one at a time. It sees how many words remain, along with per-port overflow and stale flags.

Top module: `step_capture_buffer`

## Requirements
- R1: A word is captured only in a cycle where its bit 32 is 1. Words with bit 32 at 0 leave the port's captured contents unchanged.
- R2: In register mode, a port whose step boundary has passed offers exactly one word (available count 1). That word is the last one strobed before or at the boundary.
- R3: In FIFO mode, the available count after a boundary equals the number of strobed cycles in the step that ended. Reads return those words oldest first.
- R4: A word strobed in the same cycle as a port's boundary belongs to the step that is ending.
- R5: Bit i of the mode mask controls port i, with the first port in bit 0. A bit value of 1 selects FIFO mode and 0 selects register mode.
- R6: For a port with its external pulse enabled, the boundary falls on the cycle of that port's external pulse when the pulse arrives 0 to 15 cycles after the global pulse. The cycle of the global pulse counts as lag 0.
- R7: For such a port, if no external pulse arrives within that window, the boundary falls 15 cycles after the global pulse.
- R8: For such a port, an external pulse that arrives outside the window is held over. The next global pulse is then itself that port's boundary.
- R9: Words written after a boundary never alter the contents being drained from the previous step.
- R10: In FIFO mode, strobes beyond 254 in one step are dropped and the port's overflow flag is set for that drained step. The flag clears at the next boundary that does not overflow.
- R11: In register mode, a step with no strobe repeats the previously drained word and raises the port's stale flag. A step with a strobe clears the flag.
- R12: After reset every port shows a count of 0 and both flags at 0. Each read of the selected port lowers its count by one. A read at count 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncPulse | input | 1 | Global step pulse, one cycle wide |
| extSync | input | NUM_PORTS | Per-port external step pulse |
| extSyncEn | input | NUM_PORTS | Per-port choice to follow the external pulse |
| modeMask | input | NUM_PORTS | Per-port capture mode, 1 = FIFO, 0 = register |
| portIn | input | NUM_PORTS*33 | Port p occupies bits [p*33 +: 33]; bit 32 of each is the strobe |
| drainSel | input | SEL_W | Port chosen for draining |
| drainRd | input | 1 | Advance the selected port's read position by one word |
| drainAvail | output | CNT_W | Words still unread on the selected port |
| drainData | output | DATA_W | Word at the selected port's read position |
| overflowFlags | output | NUM_PORTS | Per-port overflow flag for the drained step |
| staleFlags | output | NUM_PORTS | Per-port stale flag for the drained step |

## Verification
Every result is registered exactly once. A boundary at a clock edge makes the new count, data and flags visible right after that edge. A read at an edge updates the count and data right after that edge. For an externally timed port, a global pulse at edge E0 with an external pulse at edge Ek moves the count right after Ek. With no external pulse, the count moves right after E15. The bench therefore changes inputs and samples outputs one time unit after each rising edge. It checks that counts stay unchanged at the edge just before the expected boundary and have changed at the edge of the boundary itself.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  // strobes passed from a port's boundary control to its storage
  typedef struct packed {
    logic write;  // payload strobe this cycle
    logic swap;   // step boundary: banks change roles this cycle
  } capStrobeT;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capbuf_pkg::*;
#(
  parameter int LAG_MAX = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncPulse,
  input  logic      extSync,
  input  logic      extEn,
  input  logic      strobe,
  output capStrobeT ctl
);
  localparam int LAG_W = $clog2(LAG_MAX + 1);

  logic             winOpen;
  logic             pending;
  logic [LAG_W-1:0] lagCnt;
  logic             boundary;

  always_comb begin
    if (!extEn)
      boundary = syncPulse;
    else if (winOpen)
      boundary = extSync || syncPulse || (lagCnt == LAG_W'(LAG_MAX));
    else
      boundary = syncPulse && (extSync || pending);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !extEn) begin
      winOpen <= 1'b0;
      pending <= 1'b0;
      lagCnt  <= '0;
    end else if (winOpen) begin
      if (boundary) begin
        winOpen <= 1'b0;
        lagCnt  <= '0;
      end else begin
        lagCnt <= lagCnt + 1'b1;
      end
    end else begin
      if (syncPulse && !boundary) begin
        winOpen <= 1'b1;
        lagCnt  <= LAG_W'(1);
      end
      if (boundary)
        pending <= 1'b0;
      else if (extSync && !syncPulse)
        pending <= 1'b1;
    end
  end

  assign ctl.write = strobe;
  assign ctl.swap  = boundary;

  // R7: an open window never counts past the lag limit
  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    winOpen |-> (lagCnt != '0 && lagCnt <= LAG_W'(LAG_MAX)));
  // R6: a window only opens on the cycle after a global pulse
  a_r6_open_after_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(winOpen) |-> $past(syncPulse));
  // R8: a held-over pulse never coexists with an open window
  a_r8_pending_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(pending && winOpen));
endmodule

// File: rtl/capture_bank.sv
module capture_bank
  import capbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 254,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobeT         ctl,
  input  logic              fifoMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [CNT_W-1:0]  avail,
  output logic [DATA_W-1:0] rdData,
  output logic              ovf,
  output logic              stale
);
  logic [DATA_W-1:0] mem [2][DEPTH];

  logic              capBank;
  logic [CNT_W-1:0]  capCount;
  logic [CNT_W-1:0]  drainCount;
  logic [CNT_W-1:0]  rdPtr;
  logic              ovfCap;
  logic              ovfOut;
  logic              regSeen;
  logic              staleOut;
  logic              drainFifo;
  logic [DATA_W-1:0] regCap;
  logic [DATA_W-1:0] regOut;

  logic              full;
  logic              fifoWr;
  logic              fifoDrop;
  logic [CNT_W-1:0]  countWithWr;

  assign full        = (capCount == CNT_W'(DEPTH));
  assign fifoWr      = ctl.write && fifoMode && !full;
  assign fifoDrop    = ctl.write && fifoMode && full;
  assign countWithWr = fifoWr ? capCount + 1'b1 : capCount;

  always_ff @(posedge clk) begin
    if (fifoWr)
      mem[capBank][capCount[PTR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBank    <= 1'b0;
      capCount   <= '0;
      drainCount <= '0;
      rdPtr      <= '0;
      ovfCap     <= 1'b0;
      ovfOut     <= 1'b0;
      regSeen    <= 1'b0;
      staleOut   <= 1'b0;
      drainFifo  <= 1'b0;
      regCap     <= '0;
      regOut     <= '0;
    end else if (ctl.swap) begin
      capBank   <= ~capBank;
      capCount  <= '0;
      rdPtr     <= '0;
      drainFifo <= fifoMode;
      ovfCap    <= 1'b0;
      regSeen   <= 1'b0;
      if (fifoMode) begin
        drainCount <= countWithWr;
        ovfOut     <= ovfCap || fifoDrop;
        staleOut   <= 1'b0;
      end else begin
        drainCount <= CNT_W'(1);
        ovfOut     <= 1'b0;
        staleOut   <= !(ctl.write || regSeen);
        if (ctl.write)
          regOut <= wrData;
        else if (regSeen)
          regOut <= regCap;
      end
    end else begin
      capCount <= countWithWr;
      if (fifoDrop)
        ovfCap <= 1'b1;
      if (ctl.write && !fifoMode) begin
        regCap  <= wrData;
        regSeen <= 1'b1;
      end
      if (rdEn && rdPtr < drainCount)
        rdPtr <= rdPtr + 1'b1;
    end
  end

  assign avail  = drainCount - rdPtr;
  assign rdData = drainFifo ? mem[~capBank][rdPtr[PTR_W-1:0]] : regOut;
  assign ovf    = ovfOut;
  assign stale  = staleOut;

  // R10: the capture count never runs past the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    capCount <= CNT_W'(DEPTH));
  // R10: overflow is only reported for a FIFO-mode step
  a_r10_ovf_fifo_only: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> drainFifo);
  // R11: staleness is only reported for a register-mode step
  a_r11_stale_reg_only: assert property (@(posedge clk) disable iff (!rstN)
    staleOut |-> !drainFifo);
  // R12: reading an empty drain bank leaves it empty
  a_r12_read_empty: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && avail == '0 && !ctl.swap) |=> avail == '0);
  // R9: every boundary hands the writer the other bank
  a_r9_bank_flip: assert property (@(posedge clk) disable iff (!rstN)
    ctl.swap |=> capBank != $past(capBank));
endmodule

// File: rtl/step_capture_buffer.sv
module step_capture_buffer
  import capbuf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 254,
  parameter int LAG_MAX   = 15,
  localparam int WORD_W   = DATA_W + 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        syncPulse,
  input  logic [NUM_PORTS-1:0]        extSync,
  input  logic [NUM_PORTS-1:0]        extSyncEn,
  input  logic [NUM_PORTS-1:0]        modeMask,
  input  logic [NUM_PORTS*WORD_W-1:0] portIn,
  input  logic [SEL_W-1:0]            drainSel,
  input  logic                        drainRd,
  output logic [CNT_W-1:0]            drainAvail,
  output logic [DATA_W-1:0]           drainData,
  output logic [NUM_PORTS-1:0]        overflowFlags,
  output logic [NUM_PORTS-1:0]        staleFlags
);
  logic [CNT_W-1:0]  availArr [NUM_PORTS];
  logic [DATA_W-1:0] dataArr  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    capStrobeT         ctl;
    logic [WORD_W-1:0] word;
    logic              rdEn;

    assign word = portIn[p*WORD_W +: WORD_W];
    assign rdEn = drainRd && (drainSel == SEL_W'(p));

    capture_ctrl #(.LAG_MAX(LAG_MAX)) u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .syncPulse (syncPulse),
      .extSync   (extSync[p]),
      .extEn     (extSyncEn[p]),
      .strobe    (word[WORD_W-1]),
      .ctl       (ctl)
    );

    capture_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl),
      .fifoMode (modeMask[p]),
      .wrData   (word[DATA_W-1:0]),
      .rdEn     (rdEn),
      .avail    (availArr[p]),
      .rdData   (dataArr[p]),
      .ovf      (overflowFlags[p]),
      .stale    (staleFlags[p])
    );
  end

  always_comb begin
    drainAvail = '0;
    drainData  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (drainSel == SEL_W'(p)) begin
        drainAvail = availArr[p];
        drainData  = dataArr[p];
      end
    end
  end

  // R3: outside reset a global pulse never leaves a plain-timed port with
  // more available words than it could have captured
  a_r3_avail_bound: assert property (@(posedge clk) disable iff (!rstN)
    drainAvail <= CNT_W'(DEPTH));
endmodule

// File: tb/tb_step_capture_buffer.sv
module tb_step_capture_buffer;
  localparam int N = 4;
  localparam int W = 33;

  logic           clk = 1'b0;
  logic           rstN;
  logic           syncPulse;
  logic [N-1:0]   extSync, extSyncEn, modeMask;
  logic [N*W-1:0] portIn;
  logic [1:0]     drainSel;
  logic           drainRd;
  logic [7:0]     drainAvail;
  logic [31:0]    drainData;
  logic [N-1:0]   overflowFlags, staleFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  step_capture_buffer dut (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .extSync(extSync),
    .extSyncEn(extSyncEn), .modeMask(modeMask), .portIn(portIn),
    .drainSel(drainSel), .drainRd(drainRd), .drainAvail(drainAvail),
    .drainData(drainData), .overflowFlags(overflowFlags), .staleFlags(staleFlags)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    syncPulse = 1'b0;
    extSync   = '0;
    drainRd   = 1'b0;
    portIn    = '0;
  endtask

  task automatic put(input int p, input logic [31:0] d, input logic stb);
    portIn[p*W +: W] = {stb, d};
  endtask

  task automatic readChk(input string req, input logic [31:0] exp);
    chk(req, drainData, exp);
    drainRd = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    for (int p = 0; p < N; p++) begin
      drainSel = 2'(p);
      #1;
      chk("R12 reset count", 32'(drainAvail), 32'd0);
    end
    chk("R12 reset flags", 32'({overflowFlags, staleFlags}), 32'd0);
  endtask

  task automatic t_fifo();
    // R3 R4 R9 R12 on port 0
    for (int i = 0; i < 3; i++) begin
      put(0, 32'hA000_0000 + 32'(i), 1'b1);
      tick();
    end
    put(0, 32'hA000_0003, 1'b1);
    syncPulse = 1'b1;
    tick();
    drainSel = 2'd0;
    #1;
    chk("R3/R4 fifo count incl boundary word", 32'(drainAvail), 32'd4);
    put(0, 32'hBEEF_0000, 1'b1);
    tick();
    put(0, 32'hBEEF_0001, 1'b1);
    tick();
    chk("R9 count after new writes", 32'(drainAvail), 32'd4);
    for (int i = 0; i < 4; i++)
      readChk("R3/R9 fifo order", 32'hA000_0000 + 32'(i));
    chk("R12 count after reads", 32'(drainAvail), 32'd0);
    drainRd = 1'b1;
    tick();
    chk("R12 read at zero", 32'(drainAvail), 32'd0);
  endtask

  task automatic t_reg();
    // R1 R2 R5 R11 on port 1 (register) and port 2 (FIFO)
    put(1, 32'h1111_0001, 1'b1);
    put(2, 32'h2222_0001, 1'b1);
    tick();
    put(1, 32'h1111_0002, 1'b1);
    put(2, 32'h2222_0002, 1'b1);
    tick();
    put(1, 32'h1111_00EE, 1'b0);
    tick();
    syncPulse = 1'b1;
    tick();
    drainSel = 2'd1;
    #1;
    chk("R2/R5 reg count", 32'(drainAvail), 32'd1);
    chk("R1/R2 reg last strobed word", drainData, 32'h1111_0002);
    chk("R11 stale clear", 32'(staleFlags[1]), 32'd0);
    drainSel = 2'd2;
    #1;
    chk("R5 fifo port count", 32'(drainAvail), 32'd2);
    syncPulse = 1'b1;
    tick();
    drainSel = 2'd1;
    #1;
    chk("R11 stale repeats word", drainData, 32'h1111_0002);
    chk("R11 stale set", 32'(staleFlags[1]), 32'd1);
    put(1, 32'h1111_0003, 1'b1);
    tick();
    syncPulse = 1'b1;
    tick();
    chk("R11 fresh word", drainData, 32'h1111_0003);
    chk("R11 stale cleared", 32'(staleFlags[1]), 32'd0);
  endtask

  task automatic t_ext();
    // port 3 follows its external pulse
    repeat (20) tick();
    drainSel = 2'd3;
    put(3, 32'h3333_0000, 1'b1);
    tick();
    syncPulse = 1'b1;
    tick();                         // E0
    tick();                         // E1
    put(3, 32'h3333_0001, 1'b1);
    tick();                         // E2
    tick();                         // E3
    chk("R6 no boundary before pulse", 32'(drainAvail), 32'd0);
    tick();                         // E4
    put(3, 32'h3333_0002, 1'b1);
    extSync[3] = 1'b1;
    tick();                         // E5
    chk("R6/R4 boundary at ext pulse", 32'(drainAvail), 32'd3);
    chk("R6 first word", drainData, 32'h3333_0000);
    // R7 timeout
    put(3, 32'h3333_0003, 1'b1);
    tick();
    syncPulse = 1'b1;
    tick();                         // E0
    for (int k = 1; k < 15; k++) tick();
    chk("R7 no boundary at lag 14", 32'(drainAvail), 32'd3);
    tick();                         // E15
    chk("R7 boundary at lag 15", 32'(drainAvail), 32'd1);
    chk("R7 word", drainData, 32'h3333_0003);
    // R8 early pulse held over
    extSync[3] = 1'b1;
    tick();
    put(3, 32'h3333_0004, 1'b1);
    tick();
    put(3, 32'h3333_0005, 1'b1);
    tick();
    chk("R8 early pulse no boundary", 32'(drainAvail), 32'd1);
    syncPulse = 1'b1;
    tick();
    chk("R8 boundary at global pulse", 32'(drainAvail), 32'd2);
    chk("R8 word", drainData, 32'h3333_0004);
  endtask

  task automatic t_ovf();
    repeat (20) tick();
    drainSel = 2'd0;
    for (int i = 0; i < 256; i++) begin
      put(0, 32'hC000_0000 + 32'(i), 1'b1);
      tick();
    end
    syncPulse = 1'b1;
    tick();
    chk("R10 count capped", 32'(drainAvail), 32'd254);
    chk("R10 overflow set", 32'(overflowFlags[0]), 32'd1);
    chk("R10 first word kept", drainData, 32'hC000_0000);
    put(0, 32'hC100_0000, 1'b1);
    tick();
    syncPulse = 1'b1;
    tick();
    chk("R10 overflow cleared", 32'(overflowFlags[0]), 32'd0);
    chk("R10 next count", 32'(drainAvail), 32'd1);
  endtask

  initial begin
    rstN = 1'b0; syncPulse = 1'b0; extSync = '0; extSyncEn = 4'b1000;
    modeMask = 4'b1101; portIn = '0; drainSel = '0; drainRd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    t_reset();
    t_fifo();
    t_reg();
    t_ext();
    t_ovf();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule